// File: doc/BRIEF.md
# Slow-Clock System Timer with Alarm

This block is a system timer clocked by the fast bus clock and advanced by a one-cycle enable that marks each tick of a 32768 Hz slow clock. A programmable divider sets how many slow ticks make one step of a free-running real-time counter. The counter is 20 bits wide by default and wraps. An alarm register raises an event when the counter steps onto its value. A separate periodic down-counter produces a regular tick.

Four event sources are latched in a status register: the periodic tick, a watchdog-overflow stub input, every real-time counter step, and the alarm. A mask selects which of them drive a single level-high interrupt line. Software sets mask bits through one write-one-to-set address and clears them through another. Reading the status register returns the pending events and clears them.

A typical driver uses the counter as a clock source. It uses the periodic tick for fixed-rate interrupts and the alarm for one-shot events at an absolute time.

Top module: `slow_sys_timer`

## Requirements
- R1: After reset the counter, status and mask read 0, the prescaler reads 32768 and the interrupt output is low.
- R2: The counter steps by one after each group of P slow ticks, where P is the prescaler value. P = 1 steps on every tick, and writing the prescaler restarts the division.
- R3: The counter is CNT_W bits wide (default 20) and wraps to 0 after its all-ones value.
- R4: Status bit 3 (alarm) is set in the cycle after the counter steps onto a value equal to the alarm register.
- R5: Writing the alarm register with the counter's current value raises no alarm. The next alarm comes only after a full counter wrap, 2^CNT_W steps later.
- R6: Status bit 2 (counter step) is set on every counter step.
- R7: Writing 1s to the enable address sets those mask bits. Writing 1s to the disable address clears them. Zero bits change nothing. The mask reads back at its own address, and bit positions match the status register.
- R8: The interrupt output is high exactly when some status bit and its mask bit are both 1. A high watchdog-overflow input sets status bit 1.
- R9: A read of the status address returns the pending bits, and they are clear afterwards.
- R10: An event that arrives in the same cycle as a status read is not part of that read's data and stays pending for the next read.
- R11: With period N written, status bit 0 is set after N slow ticks and again every N ticks after that. Writing the period restarts the down-count.
- R12: A period value of 0 gives one periodic tick per 65536 slow ticks.
- R13: Word addresses: 0 period, 1 prescaler, 2 alarm, 3 status (read clears), 4 mask enable, 5 mask disable, 6 mask read, 7 counter read. Read data is valid in the same cycle as the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| slow_tick | input | 1 | One-cycle enable per slow-clock tick |
| wdog_ovf | input | 1 | Watchdog overflow stub, sets status bit 1 while high |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| irq | output | 1 | Level-high shared interrupt |

## Verification
The event inputs can collide with a status read. The alarm and counter-step sources fire on slow ticks, the watchdog stub fires on a pin, and a read of the status address clears everything in the same cycle. The bench drives the watchdog input in the very cycle that it reads status. It expects bit 1 absent from that read's data and present in the read after it. The alarm cancel is also provoked by rewriting the alarm with the live count, and is judged over a full wrap of a narrowed counter.

// File: rtl/sst_pkg.sv
package sst_pkg;
  localparam int unsigned SRC_N    = 4;
  localparam int unsigned SRC_PIT  = 0;
  localparam int unsigned SRC_WDOG = 1;
  localparam int unsigned SRC_STEP = 2;
  localparam int unsigned SRC_ALM  = 3;

  typedef enum logic [2:0] {
    A_PERIOD = 3'd0,
    A_PRESC  = 3'd1,
    A_ALARM  = 3'd2,
    A_STATUS = 3'd3,
    A_IEN    = 3'd4,
    A_IDIS   = 3'd5,
    A_MASK   = 3'd6,
    A_COUNT  = 3'd7
  } sst_addr_e;
endpackage

// File: rtl/sst_rtc.sv
// Prescaler and free-running real-time counter.
module sst_rtc #(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 32768
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             presc_we,
  input  logic [DIV_W-1:0] presc_wdata,
  output logic [DIV_W-1:0] presc_q,
  output logic [CNT_W-1:0] rtc_q,
  output logic [CNT_W-1:0] rtc_nxt,
  output logic             step_o
);
  logic [DIV_W-1:0] div_q, div_d, presc_d, terminal;
  logic [CNT_W-1:0] rtc_d;

  // A prescaler of 0 wraps to all ones here, i.e. a 2^DIV_W divide.
  assign terminal = presc_q - DIV_W'(1);
  assign rtc_nxt  = rtc_q + CNT_W'(1);

  always_comb begin
    presc_d = presc_q;
    div_d   = div_q;
    step_o  = 1'b0;
    if (presc_we) begin
      presc_d = presc_wdata;
      div_d   = '0;
    end else if (tick) begin
      if (div_q == terminal) begin
        div_d  = '0;
        step_o = 1'b1;
      end else begin
        div_d = div_q + DIV_W'(1);
      end
    end
    rtc_d = step_o ? rtc_nxt : rtc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      presc_q <= DIV_W'(DIV_RST);
      div_q   <= '0;
      rtc_q   <= '0;
    end else begin
      presc_q <= presc_d;
      div_q   <= div_d;
      rtc_q   <= rtc_d;
    end
  end

  p_rtc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rtc_q != $past(rtc_q)) |-> (rtc_q == $past(rtc_q) + CNT_W'(1)));
  p_rtc_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(rtc_q));
endmodule

// File: rtl/sst_alarm.sv
// Absolute-time alarm: equality with the value the counter steps onto.
module sst_alarm #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             alm_we,
  input  logic [CNT_W-1:0] alm_wdata,
  input  logic             step_i,
  input  logic [CNT_W-1:0] rtc_q,
  input  logic [CNT_W-1:0] rtc_nxt,
  output logic [CNT_W-1:0] alarm_q,
  output logic             match_o
);
  logic [CNT_W-1:0] alarm_d;

  // Matching only on a step means a value equal to the present count
  // cannot fire until the counter comes round again.
  always_comb begin
    alarm_d = alm_we ? alm_wdata : alarm_q;
    match_o = step_i && (rtc_nxt == alarm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) alarm_q <= '1;
    else        alarm_q <= alarm_d;
  end

  p_alarm_hit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> (rtc_q == $past(alarm_q)));
  p_cancel_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (alm_we && (alm_wdata == rtc_q) && !step_i) |=> !match_o);
endmodule

// File: rtl/sst_pit.sv
// Periodic interval down-counter with automatic reload.
module sst_pit #(
  parameter int unsigned PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             per_we,
  input  logic [PER_W-1:0] per_wdata,
  output logic [PER_W-1:0] per_q,
  output logic             evt_o
);
  logic [PER_W-1:0] per_d, cnt_q, cnt_d, reload;

  // Period 0 reloads all ones, giving 2^PER_W ticks per event.
  assign reload = per_q - PER_W'(1);

  always_comb begin
    per_d = per_q;
    cnt_d = cnt_q;
    evt_o = 1'b0;
    if (per_we) begin
      per_d = per_wdata;
      cnt_d = per_wdata - PER_W'(1);
    end else if (tick) begin
      if (cnt_q == '0) begin
        evt_o = 1'b1;
        cnt_d = reload;
      end else begin
        cnt_d = cnt_q - PER_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= '0;
      cnt_q <= '1;
    end else begin
      per_q <= per_d;
      cnt_q <= cnt_d;
    end
  end

  p_pit_reload_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_o && !per_we) |=> (cnt_q == $past(per_q) - PER_W'(1)));
  p_pit_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !per_we) |=> $stable(cnt_q));
endmodule

// File: rtl/sst_irq.sv
// Status latch with clear-on-read and set/clear mask.
module sst_irq #(
  parameter int unsigned SRC_N = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] ev_i,
  input  logic             rd_clr,
  input  logic             en_we,
  input  logic             dis_we,
  input  logic [SRC_N-1:0] wbits,
  output logic [SRC_N-1:0] status_q,
  output logic [SRC_N-1:0] mask_q,
  output logic             irq_o
);
  logic [SRC_N-1:0] status_d, mask_d;

  always_comb begin
    // Events in the read cycle are OR-ed after the clear so none is lost.
    status_d = (rd_clr ? '0 : status_q) | ev_i;
    mask_d   = mask_q;
    if (en_we)  mask_d = mask_d | wbits;
    if (dis_we) mask_d = mask_d & ~wbits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign irq_o = |(status_q & mask_q);

  p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en_we |=> ((mask_q & $past(wbits)) == $past(wbits)));
  p_mask_clr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    dis_we |=> ((mask_q & $past(wbits)) == '0));
  p_stat_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && (ev_i == '0)) |=> (status_q == '0));

  for (genvar i = 0; i < SRC_N; i++) begin : g_keep
    p_stat_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ev_i[i] |=> status_q[i]);
  end
endmodule

// File: rtl/slow_sys_timer.sv
module slow_sys_timer #(
  parameter int unsigned CNT_W   = 20,
  parameter int unsigned DIV_W   = 16,
  parameter int unsigned DIV_RST = 32768,
  parameter int unsigned PER_W   = 16,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slow_tick,
  input  logic              wdog_ovf,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  import sst_pkg::*;

  logic [1:0] rst_sync_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  logic wr_en, rd_en;
  logic we_period, we_presc, we_alarm, we_ien, we_idis, rd_status;
  assign wr_en     = bus_sel && bus_wr;
  assign rd_en     = bus_sel && !bus_wr;
  assign we_period = wr_en && (bus_addr == A_PERIOD);
  assign we_presc  = wr_en && (bus_addr == A_PRESC);
  assign we_alarm  = wr_en && (bus_addr == A_ALARM);
  assign we_ien    = wr_en && (bus_addr == A_IEN);
  assign we_idis   = wr_en && (bus_addr == A_IDIS);
  assign rd_status = rd_en && (bus_addr == A_STATUS);

  logic [DIV_W-1:0] presc_q;
  logic [CNT_W-1:0] rtc_q, rtc_nxt, alarm_q;
  logic [PER_W-1:0] per_q;
  logic             step, alm_hit, pit_evt;
  logic [SRC_N-1:0] ev, status_q, mask_q;

  sst_rtc #(.CNT_W(CNT_W), .DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_rtc (
    .clk(clk), .rst_n(rst_sn), .tick(slow_tick),
    .presc_we(we_presc), .presc_wdata(bus_wdata[DIV_W-1:0]),
    .presc_q(presc_q), .rtc_q(rtc_q), .rtc_nxt(rtc_nxt), .step_o(step)
  );

  sst_alarm #(.CNT_W(CNT_W)) u_alarm (
    .clk(clk), .rst_n(rst_sn), .alm_we(we_alarm),
    .alm_wdata(bus_wdata[CNT_W-1:0]), .step_i(step),
    .rtc_q(rtc_q), .rtc_nxt(rtc_nxt), .alarm_q(alarm_q), .match_o(alm_hit)
  );

  sst_pit #(.PER_W(PER_W)) u_pit (
    .clk(clk), .rst_n(rst_sn), .tick(slow_tick), .per_we(we_period),
    .per_wdata(bus_wdata[PER_W-1:0]), .per_q(per_q), .evt_o(pit_evt)
  );

  always_comb begin
    ev           = '0;
    ev[SRC_PIT]  = pit_evt;
    ev[SRC_WDOG] = wdog_ovf;
    ev[SRC_STEP] = step;
    ev[SRC_ALM]  = alm_hit;
  end

  sst_irq #(.SRC_N(SRC_N)) u_irq (
    .clk(clk), .rst_n(rst_sn), .ev_i(ev), .rd_clr(rd_status),
    .en_we(we_ien), .dis_we(we_idis), .wbits(bus_wdata[SRC_N-1:0]),
    .status_q(status_q), .mask_q(mask_q), .irq_o(irq)
  );

  logic unused_wdata;
  assign unused_wdata = ^bus_wdata;

  always_comb begin
    bus_rdata = '0;
    if (rd_en) begin
      unique case (bus_addr)
        A_PERIOD: bus_rdata = DATA_W'(per_q);
        A_PRESC:  bus_rdata = DATA_W'(presc_q);
        A_ALARM:  bus_rdata = DATA_W'(alarm_q);
        A_STATUS: bus_rdata = DATA_W'(status_q);
        A_MASK:   bus_rdata = DATA_W'(mask_q);
        A_COUNT:  bus_rdata = DATA_W'(rtc_q);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: tb/tb_slow_sys_timer.sv
`timescale 1ns/1ps
module tb_slow_sys_timer;
  localparam int CW = 12;
  localparam logic [CW-1:0] CMASK = '1;

  logic clk = 1'b0;
  logic rst_n, slow_tick, wdog_ovf, bus_sel, bus_wr, irq;
  logic [2:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  slow_sys_timer #(.CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .wdog_ovf(wdog_ovf),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    @(posedge clk);
    #1 bus_sel = 0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_sel = 0; bus_wr = 0;
  endtask

  task automatic ticks(input int n);
    if (n > 0) begin
      @(negedge clk);
      slow_tick = 1;
      repeat (n) @(posedge clk);
      #1 slow_tick = 0;
    end
  endtask

  function automatic int exp_count(input int c0, input int n, input int p);
    return (c0 + n / p) & int'(CMASK);
  endfunction

  function automatic logic [3:0] mask_upd(input logic [3:0] m, input bit en, input logic [3:0] b);
    return en ? (m | b) : (m & ~b);
  endfunction

  initial begin
    #1_900_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, c;
    logic [3:0] m;
    void'($urandom(32'd1234));
    rst_n = 0; slow_tick = 0; wdog_ovf = 0; bus_sel = 0; bus_wr = 0;
    bus_addr = '0; bus_wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;
    repeat (4) @(posedge clk);

    // R1 reset state (R13 addresses)
    rd(3'd3, d); chk(d == 0, "R1 status", d, 0);
    rd(3'd6, d); chk(d == 0, "R1 mask", d, 0);
    rd(3'd7, d); chk(d == 0, "R1 count", d, 0);
    rd(3'd1, d); chk(d == 32768, "R1 prescaler", d, 32768);
    chk(irq == 0, "R1 irq", irq, 0);

    // R2 default divide, R6 step bit
    ticks(32767);
    rd(3'd7, d); chk(d == 0, "R2 default before step", d, 0);
    rd(3'd3, d); chk(d[2] == 0, "R6 no step yet", d[2], 0);
    ticks(1);
    rd(3'd7, d); chk(d == 1, "R2 default step", d, 1);
    rd(3'd3, d); chk(d[2] == 1, "R6 step bit", d[2], 1);

    // R2 random prescaler values
    for (int i = 0; i < 10; i++) begin
      int p, n;
      p = 1 + int'($urandom % 5);
      n = int'($urandom % 24);
      wr(3'd1, p);
      rd(3'd7, c);
      ticks(n);
      rd(3'd7, d);
      chk(d == exp_count(int'(c), n, p), "R2 divide", d, exp_count(int'(c), n, p));
    end

    // R4 alarm
    wr(3'd1, 1);
    rd(3'd7, c);
    wr(3'd2, (c + 3) & CMASK);
    rd(3'd3, d);
    ticks(2);
    rd(3'd3, d); chk(d[3] == 0, "R4 alarm early", d[3], 0);
    ticks(1);
    rd(3'd3, d); chk(d[3] == 1, "R4 alarm hit", d[3], 1);

    // R5 cancel, R3 wrap
    rd(3'd7, c);
    wr(3'd2, c);
    rd(3'd3, d);
    ticks(1);
    rd(3'd3, d); chk(d[3] == 0, "R5 cancel no match", d[3], 0);
    ticks((1 << CW) - 2);
    rd(3'd3, d); chk(d[3] == 0, "R5 no match before wrap", d[3], 0);
    ticks(1);
    rd(3'd3, d); chk(d[3] == 1, "R5 match after wrap", d[3], 1);
    rd(3'd7, d); chk(d == c, "R3 wrap count", d, c);

    // R7 random mask set/clear
    m = '0;
    for (int i = 0; i < 16; i++) begin
      bit en;
      logic [3:0] b;
      en = bit'($urandom % 2);
      b = 4'($urandom);
      wr(en ? 3'd4 : 3'd5, {28'h0, b});
      m = mask_upd(m, en, b);
      rd(3'd6, d); chk(d[3:0] == m, "R7 mask", d, m);
    end

    // R8 irq from watchdog with random masks, R9 clear on read
    for (int i = 0; i < 6; i++) begin
      logic [3:0] b;
      b = 4'($urandom);
      wr(3'd5, 32'hF);
      wr(3'd4, {28'h0, b});
      rd(3'd3, d);
      @(negedge clk) wdog_ovf = 1;
      @(posedge clk) #1 wdog_ovf = 0;
      @(negedge clk);
      chk(irq == b[1], "R8 irq", irq, b[1]);
    end
    rd(3'd3, d); chk(d[1] == 1, "R9 read returns pending", d[1], 1);
    rd(3'd3, d); chk(d == 0, "R9 cleared", d, 0);
    @(negedge clk); chk(irq == 0, "R8 irq low after clear", irq, 0);

    // R10 event collides with status read
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 3'd3; wdog_ovf = 1;
    #1 d = bus_rdata;
    @(posedge clk) #1 begin bus_sel = 0; wdog_ovf = 0; end
    chk(d[1] == 0, "R10 not in same read", d[1], 0);
    rd(3'd3, d); chk(d[1] == 1, "R10 kept pending", d[1], 1);

    // R11 periodic tick
    wr(3'd0, 5);
    rd(3'd3, d);
    ticks(4);
    rd(3'd3, d); chk(d[0] == 0, "R11 pit early", d[0], 0);
    ticks(1);
    rd(3'd3, d); chk(d[0] == 1, "R11 pit expiry", d[0], 1);
    ticks(4);
    rd(3'd3, d); chk(d[0] == 0, "R11 reload early", d[0], 0);
    ticks(1);
    rd(3'd3, d); chk(d[0] == 1, "R11 reload expiry", d[0], 1);
    ticks(3);
    wr(3'd0, 5);
    ticks(4);
    rd(3'd3, d); chk(d[0] == 0, "R11 restart on write", d[0], 0);

    // R12 period 0
    wr(3'd0, 0);
    rd(3'd3, d);
    ticks(65535);
    rd(3'd3, d); chk(d[0] == 0, "R12 period0 early", d[0], 0);
    ticks(1);
    rd(3'd3, d); chk(d[0] == 1, "R12 period0 expiry", d[0], 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule